// File: doc/BRIEF.md
# Non-Volatile Store Sequencer

This block controls the copy of one wiper setting into an emulated non-volatile cell array. A serial front end, which is not part of this block, decodes each frame. When a frame completes, it gives one strobe carrying the channel number and the new 8-bit setting. The block writes that setting into the addressed wiper register straight away.

The program input is sampled on the same edge as the strobe. If it is high there, a store is armed. An active-low ready/busy output then drops for a timed erase/write interval, and the cell for that channel is updated at the end of the interval. A supply-good flag gates both the start of a store and its final commit.

At power-up the asynchronous reset copies every non-volatile cell into the wiper registers. No clock edge is needed for this, so the wiper outputs are meaningful before the clock starts. The cells themselves are never cleared by reset.

The state machine has three states:
- `ST_IDLE`: ready, accepting frames.
- `ST_BURN`: the timed programming interval.
- `ST_SEAL`: one cycle that commits the cell.

It has three transitions:
- *arm* (`ST_IDLE`→`ST_BURN`): strobe, program input high and supply good, all on one edge.
- *elapse* (`ST_BURN`→`ST_SEAL`): the interval counter has reached zero.
- *seal* (`ST_SEAL`→`ST_IDLE`): always taken. The cell is written only if the supply is still good.

Top module: `nvs_store_seq`

## Requirements
- R1: While reset is low, and before any clock edge, every wiper output equals the matching non-volatile cell, ready/busy reads 1 and the hold output reads 0. The cells themselves keep their contents.
- R2: In `ST_IDLE`, a frame strobe writes the frame data into wiper channel `frame_chan_i` at that edge. Channel c occupies bits [c*DW +: DW] of `wiper_o` and `nv_o`.
- R3: When the arm condition holds at an edge, ready/busy reads 0 from that edge for exactly T_PROG+1 clock cycles and then returns to 1.
- R4: A completed store writes the armed frame's data into cell `frame_chan_i` only. The write lands at the edge that ends the busy interval, and every other cell is unchanged.
- R5: A high program input without a strobe on the same edge has no effect: ready/busy stays 1 and no cell changes. This includes a program input raised one cycle after the strobe.
- R6: A strobe with the program input low updates only the wiper register. Ready/busy stays 1 and no cell changes.
- R7: If the supply-good flag is 0 at the arm edge, no store begins. Ready/busy stays 1 and no cell changes, while the wiper is still updated.
- R8: If the supply-good flag is 0 during `ST_SEAL`, the interval still ends normally with ready/busy back at 1, but no cell is written.
- R9: While ready/busy is 0, the hold output is 1 and frame strobes are ignored: no wiper changes.
- R10: A reset after a completed store restores the stored value into that wiper. Channels whose store was suppressed come back with their older cell value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, kept running through the store interval |
| rst_n | input | 1 | Asynchronous active-low power-on reset; triggers restore |
| prog_i | input | 1 | Program request level |
| frame_done_i | input | 1 | One-cycle strobe on the clock after the last data bit |
| frame_chan_i | input | CH_W | Channel addressed by the frame |
| frame_data_i | input | DW | Setting carried by the frame |
| supply_ok_i | input | 1 | 1 when the supply is high enough to program |
| rdy_busy_n_o | output | 1 | 1 = ready, 0 = store in progress |
| sif_hold_o | output | 1 | Tells the serial front end to ignore input and keep its output quiet |
| wiper_o | output | NCH*DW | Volatile wiper settings, channel-packed |
| nv_o | output | NCH*DW | Non-volatile cell contents, channel-packed |

## Verification
The bench builds the block with T_PROG = 6, NCH = 4, DW = 8 and a distinct nonzero initial value in each cell. The short interval makes it possible to count the exact busy length and its end edge cycle by cycle. It also lets a second frame land during busy, and lets the supply drop just before the commit. The distinct cell values show that a store touches only one channel and that reset brings back the right per-channel value.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BURN = 2'd1,
        ST_SEAL = 2'd2
    } nvs_state_e;

endpackage

// File: rtl/nvs_cell_array.sv
// Emulated non-volatile cells: hold their value across reset, written only on commit.
module nvs_cell_array #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter logic [NCH*DW-1:0] NV_INIT = '0,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [CH_W-1:0]   sel_i,
    input  logic [DW-1:0]     din_i,
    output logic [NCH*DW-1:0] cells_o
);

    for (genvar g = 0; g < NCH; g++) begin : g_cell
        logic [DW-1:0] cell_q = NV_INIT[g*DW +: DW];

        always_ff @(posedge clk) begin
            if (we_i && (sel_i == CH_W'(g))) begin
                cell_q <= din_i;
            end
        end

        assign cells_o[g*DW +: DW] = cell_q;
    end

endmodule

// File: rtl/nvs_wiper_bank.sv
// Volatile wiper registers; the asynchronous reset reloads them from the cells.
module nvs_wiper_bank #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [CH_W-1:0]   sel_i,
    input  logic [DW-1:0]     din_i,
    input  logic [NCH*DW-1:0] restore_i,
    output logic [NCH*DW-1:0] wiper_o
);

    for (genvar g = 0; g < NCH; g++) begin : g_wiper
        logic [DW-1:0] w_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                w_q <= restore_i[g*DW +: DW];
            end else if (we_i && (sel_i == CH_W'(g))) begin
                w_q <= din_i;
            end
        end

        assign wiper_o[g*DW +: DW] = w_q;
    end

endmodule

// File: rtl/nvs_timer.sv
// Down-counter that times the programming interval in clock cycles.
module nvs_timer #(
    parameter int T_PROG = 2000,
    localparam int CNT_W = $clog2(T_PROG + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CNT_W'(T_PROG - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

    // R3: the interval counter moves down by exactly one per cycle
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/nvs_store_seq.sv
module nvs_store_seq #(
    parameter int NCH    = 4,
    parameter int DW     = 8,
    parameter int T_PROG = 2000,
    parameter logic [NCH*DW-1:0] NV_INIT = '0,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_i,
    input  logic              frame_done_i,
    input  logic [CH_W-1:0]   frame_chan_i,
    input  logic [DW-1:0]     frame_data_i,
    input  logic              supply_ok_i,
    output logic              rdy_busy_n_o,
    output logic              sif_hold_o,
    output logic [NCH*DW-1:0] wiper_o,
    output logic [NCH*DW-1:0] nv_o
);

    import nvs_pkg::*;

    nvs_state_e      state_q, state_d;
    logic [CH_W-1:0] arm_chan_q;
    logic [DW-1:0]   arm_data_q;
    logic            arm;
    logic            timer_done;
    logic            wiper_we;
    logic            cell_we;

    assign arm = (state_q == ST_IDLE) && frame_done_i && prog_i && supply_ok_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (arm)        state_d = ST_BURN;
            ST_BURN: if (timer_done) state_d = ST_SEAL;
            ST_SEAL:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // armed frame capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_chan_q <= '0;
            arm_data_q <= '0;
        end else if (arm) begin
            arm_chan_q <= frame_chan_i;
            arm_data_q <= frame_data_i;
        end
    end

    // outputs
    always_comb begin
        rdy_busy_n_o = 1'b1;
        wiper_we     = 1'b0;
        cell_we      = 1'b0;
        unique case (state_q)
            ST_IDLE: wiper_we     = frame_done_i;
            ST_BURN: rdy_busy_n_o = 1'b0;
            ST_SEAL: begin
                rdy_busy_n_o = 1'b0;
                cell_we      = supply_ok_i;
            end
            default: rdy_busy_n_o = 1'b1;
        endcase
        sif_hold_o = !rdy_busy_n_o;
    end

    nvs_timer #(.T_PROG(T_PROG)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (arm),
        .done_o (timer_done)
    );

    nvs_cell_array #(.NCH(NCH), .DW(DW), .NV_INIT(NV_INIT)) u_cells (
        .clk     (clk),
        .we_i    (cell_we),
        .sel_i   (arm_chan_q),
        .din_i   (arm_data_q),
        .cells_o (nv_o)
    );

    nvs_wiper_bank #(.NCH(NCH), .DW(DW)) u_wipers (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wiper_we),
        .sel_i     (frame_chan_i),
        .din_i     (frame_data_i),
        .restore_i (nv_o),
        .wiper_o   (wiper_o)
    );

    // R3: an armed store pulls ready/busy low on the next cycle
    a_r3_arm_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && frame_done_i && prog_i && supply_ok_i) |=> !rdy_busy_n_o);

    // R5: with no strobe while idle, ready/busy stays high
    a_r5_no_frame_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !frame_done_i) |=> rdy_busy_n_o);

    // R7: a low supply at the arm edge suppresses the store
    a_r7_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && frame_done_i && prog_i && !supply_ok_i) |=> rdy_busy_n_o);

    // R4: cells change only from the commit state
    a_r4_cells_only_on_seal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SEAL) |=> $stable(nv_o));

    // R9: frames during busy leave the wipers untouched
    a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_busy_n_o && frame_done_i) |=> $stable(wiper_o));

    // R8: a low supply during commit leaves the cells unchanged
    a_r8_brownout: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEAL && !supply_ok_i) |=> $stable(nv_o));

endmodule

// File: tb/nvs_store_seq_tb.sv
module nvs_store_seq_tb;

    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int TP  = 6;
    localparam logic [NCH*DW-1:0] INIT = 32'h44_33_22_11;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic prog = 1'b0;
    logic fdone = 1'b0;
    logic [1:0] fchan = '0;
    logic [DW-1:0] fdata = '0;
    logic sok = 1'b1;
    logic rdy, hold;
    logic [NCH*DW-1:0] wiper, nv;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_nv [NCH];

    always #5 clk = ~clk;

    nvs_store_seq #(.NCH(NCH), .DW(DW), .T_PROG(TP), .NV_INIT(INIT)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_i       (prog),
        .frame_done_i (fdone),
        .frame_chan_i (fchan),
        .frame_data_i (fdata),
        .supply_ok_i  (sok),
        .rdy_busy_n_o (rdy),
        .sif_hold_o   (hold),
        .wiper_o      (wiper),
        .nv_o         (nv)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] wp(input int c);
        return wiper[c*DW +: DW];
    endfunction

    function automatic logic [DW-1:0] cl(input int c);
        return nv[c*DW +: DW];
    endfunction

    task automatic chk_cells(input string tag);
        for (int c = 0; c < NCH; c++) chk(tag, cl(c), exp_nv[c]);
    endtask

    // drive one frame strobe at a negedge; returns at the following negedge
    task automatic frame(input int c, input logic [DW-1:0] d, input logic p, input logic s);
        fchan = c[1:0]; fdata = d; prog = p; sok = s; fdone = 1'b1;
        @(negedge clk);
        fdone = 1'b0; prog = 1'b0;
    endtask

    task automatic t_reset;
        for (int c = 0; c < NCH; c++) exp_nv[c] = INIT[c*DW +: DW];
        #1 rst_n = 1'b0;
        #2;
        for (int c = 0; c < NCH; c++) chk("R1 restore before clock", wp(c), exp_nv[c]);
        chk("R1 ready high", rdy, 1'b1);
        chk("R1 hold low", hold, 1'b0);
        chk_cells("R1 cells kept");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_volatile;
        frame(2, 8'h9B, 1'b0, 1'b1);
        chk("R2 wiper write", wp(2), 8'h9B);
        chk("R6 ready stays high", rdy, 1'b1);
        repeat (2) @(negedge clk);
        chk_cells("R6 cells unchanged");
    endtask

    task automatic t_store;
        logic [DW-1:0] w2;
        w2 = wp(2);
        frame(1, 8'hA5, 1'b1, 1'b1);
        chk("R3 busy after arm", rdy, 1'b0);
        chk("R9 hold during busy", hold, 1'b1);
        chk("R2 wiper takes armed data", wp(1), 8'hA5);
        // frame during busy must be ignored
        fchan = 2'd2; fdata = 8'hEE; prog = 1'b1; fdone = 1'b1;
        @(negedge clk);
        fdone = 1'b0; prog = 1'b0;
        chk("R9 busy frame ignored", wp(2), w2);
        repeat (TP - 1) @(negedge clk);
        chk("R3 still busy at last cycle", rdy, 1'b0);
        chk_cells("R4 no early commit");
        @(negedge clk);
        chk("R3 ready after T_PROG+1", rdy, 1'b1);
        exp_nv[1] = 8'hA5;
        chk_cells("R4 only addressed cell");
    endtask

    task automatic t_prog_no_frame;
        prog = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk("R5 prog alone", rdy, 1'b1);
        end
        prog = 1'b0;
        frame(0, 8'h77, 1'b0, 1'b1);
        prog = 1'b1;
        @(negedge clk);
        chk("R5 late prog ignored", rdy, 1'b1);
        @(negedge clk);
        prog = 1'b0;
        chk_cells("R5 cells unchanged");
    endtask

    task automatic t_low_supply;
        frame(3, 8'h3C, 1'b1, 1'b0);
        chk("R7 ready held high", rdy, 1'b1);
        chk("R7 wiper still updates", wp(3), 8'h3C);
        repeat (TP + 2) @(negedge clk);
        chk("R7 ready still high", rdy, 1'b1);
        chk_cells("R7 no write");
        sok = 1'b1;
    endtask

    task automatic t_brownout;
        frame(3, 8'h5C, 1'b1, 1'b1);
        chk("R8 store started", rdy, 1'b0);
        sok = 1'b0;
        repeat (TP + 1) @(negedge clk);
        chk("R8 ready returns", rdy, 1'b1);
        chk_cells("R8 commit suppressed");
        sok = 1'b1;
    endtask

    task automatic t_restore;
        frame(1, 8'h01, 1'b0, 1'b1);
        chk("R2 overwrite wiper", wp(1), 8'h01);
        rst_n = 1'b0;
        #1;
        chk("R10 stored value back", wp(1), 8'hA5);
        chk("R10 suppressed channel old value", wp(3), 8'h44);
        chk("R10 untouched channel", wp(0), 8'h11);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ready after reset", rdy, 1'b1);
    endtask

    logic finished = 1'b0;

    initial begin
        t_reset();
        t_volatile();
        t_store();
        t_prog_no_frame();
        t_low_supply();
        t_brownout();
        t_restore();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule